// File: doc/BRIEF.md
# SPI NAND Page Command Controller

This controller takes one of three page-level requests (read a page into the device cache and stream it out, program a page from the host buffer, erase a block) and turns each into the ordered series of single flash commands a serial NAND part needs. It hands those commands one at a time to a SPI operation sequencer below it. The sequencer carries out the bus transfer and moves any page data through its own buffer. For each request the controller inserts the write-enable prerequisite where one is needed. It polls the status feature register until the busy flag drops and then turns the final status byte into a 3-bit result code, which it presents with a one-cycle done pulse.

Each request carries a row address (page or block) and a column address (byte offset into the cache). A fast flag picks the fast cache-read opcode with its dummy bytes. A keep flag picks the cache-load opcode that leaves the rest of the cache unchanged. A poll limit stops a sequence whose busy flag never clears and reports a timeout.

Top module: `nand_page_ctrl`

## Requirements
- R1: After reset, busy_o, op_valid_o and done_o are 0 and result_o is 0.
- R2: A read (req_kind_i = 0) issues 0x13 with the row as a 3-byte address and no data. It then polls, and then issues a cache read with the column as a 2-byte address and PAGE_BYTES data bytes in. With req_fast_i = 0 the cache read uses opcode 0x03 and 0 dummy bytes.
- R3: With req_fast_i = 1, the cache read uses opcode 0x0B and FAST_DUMMY dummy bytes.
- R4: A poll is opcode 0x0F with address 0xC0 in 1 address byte and 1 data byte in. Polls repeat while bit 0 of the returned byte is 1.
- R5: A program (req_kind_i = 1) issues 0x06, then a cache load with the 2-byte column and PAGE_BYTES data bytes out, then 0x10 with the 3-byte row, then polls. The load opcode is 0x02 when req_keep_i = 0 and 0x84 when req_keep_i = 1.
- R6: An erase (req_kind_i = 2) issues 0x06, then 0xD8 with the 3-byte row, then polls.
- R7: A read takes its result from status bits [5:4] of the last poll. 00 gives result 0, 01 gives 1, and 10 or 11 gives 2. The cache read is issued in every case.
- R8: A program gives result 3 when bit 3 of the last poll is 1, and an erase gives 3 when bit 2 is 1. Otherwise the result is 0, and the other operation's fail bit has no effect.
- R9: If MAX_POLLS polls in a row return busy, the result is 4 and no further command is issued. If busy clears on poll number MAX_POLLS, the sequence continues normally.
- R10: done_o is a one-cycle pulse in the cycle after the final command completes, with result_o valid in that cycle. Requests made while busy_o = 1, and requests with req_kind_i = 3, are ignored.
- R11: In the done_o cycle the controller is idle and accepts a new request.
- R12: Each command's fields stay stable on the op port from the cycle op_valid_o rises until the cycle op_done_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_kind_i | input | 2 | 0 read, 1 program, 2 erase |
| req_row_i | input | ROW_W | Page or block row address |
| req_col_i | input | COL_W | Byte column in the cache |
| req_fast_i | input | 1 | Use fast cache read |
| req_keep_i | input | 1 | Load cache without clearing it |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | 0 ok, 1 corrected, 2 uncorrectable, 3 fail, 4 timeout |
| op_valid_o | output | 1 | Command presented to the sequencer |
| op_code_o | output | 8 | Command opcode |
| op_addr_o | output | 24 | Address value, right aligned |
| op_addr_bytes_o | output | 2 | Address byte count |
| op_dummy_o | output | 2 | Dummy byte count |
| op_len_o | output | LEN_W | Data byte count |
| op_write_o | output | 1 | 1 data out, 0 data in |
| op_done_i | input | 1 | Sequencer finished the presented command |
| op_rdata_i | input | 8 | First returned data byte |

## Verification
Two events can fall in the same cycle. The poll counter can reach its limit in the same cycle that a poll returns not-busy, and a new request can arrive in the same cycle as the done pulse. The bench covers the first by scripting MAX_POLLS-1 busy replies followed by a clear one; the run must continue into the cache read and must not report a timeout. It covers the second by driving a request in the cycle done_o is seen. That request must be accepted, must produce its full command series, and must keep the earlier result intact.

// File: rtl/nand_ctrl_pkg.sv
package nand_ctrl_pkg;
  localparam int ADDR_W = 24;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_PROG  = 2'd1,
    KIND_ERASE = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WREN, ST_LOAD, ST_EXEC, ST_PGRD, ST_ERASE, ST_POLL, ST_CACHE
  } step_e;

  localparam logic [2:0] RES_OK      = 3'd0;
  localparam logic [2:0] RES_CORR    = 3'd1;
  localparam logic [2:0] RES_UNCOR   = 3'd2;
  localparam logic [2:0] RES_FAIL    = 3'd3;
  localparam logic [2:0] RES_TIMEOUT = 3'd4;

  localparam logic [7:0] OPC_WREN      = 8'h06;
  localparam logic [7:0] OPC_LOAD      = 8'h02;
  localparam logic [7:0] OPC_LOAD_KEEP = 8'h84;
  localparam logic [7:0] OPC_EXEC      = 8'h10;
  localparam logic [7:0] OPC_PGRD      = 8'h13;
  localparam logic [7:0] OPC_ERASE     = 8'hD8;
  localparam logic [7:0] OPC_GETF      = 8'h0F;
  localparam logic [7:0] OPC_CACHE     = 8'h03;
  localparam logic [7:0] OPC_CACHE_F   = 8'h0B;
  localparam logic [7:0] STATUS_ADDR   = 8'hC0;
endpackage

// File: rtl/nand_op_fmt.sv
module nand_op_fmt
  import nand_ctrl_pkg::*;
#(
  parameter int ROW_W      = 24,
  parameter int COL_W      = 12,
  parameter int PAGE_BYTES = 2112,
  parameter int FAST_DUMMY = 1,
  parameter int LEN_W      = $clog2(PAGE_BYTES + 1)
) (
  input  step_e              step_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic [COL_W-1:0]   col_i,
  input  logic               fast_i,
  input  logic               keep_i,
  output logic [7:0]         code_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [1:0]         abytes_o,
  output logic [1:0]         dummy_o,
  output logic [LEN_W-1:0]   len_o,
  output logic               write_o
);
  logic [ADDR_W-1:0] row_ext, col_ext;
  assign row_ext = ADDR_W'(row_i);
  assign col_ext = ADDR_W'(col_i);

  always_comb begin
    code_o   = 8'h00;
    addr_o   = '0;
    abytes_o = 2'd0;
    dummy_o  = 2'd0;
    len_o    = '0;
    write_o  = 1'b0;
    unique case (step_i)
      ST_WREN:  code_o = OPC_WREN;
      ST_LOAD: begin
        code_o   = keep_i ? OPC_LOAD_KEEP : OPC_LOAD;
        addr_o   = col_ext;
        abytes_o = 2'd2;
        len_o    = LEN_W'(PAGE_BYTES);
        write_o  = 1'b1;
      end
      ST_EXEC: begin
        code_o   = OPC_EXEC;
        addr_o   = row_ext;
        abytes_o = 2'd3;
      end
      ST_PGRD: begin
        code_o   = OPC_PGRD;
        addr_o   = row_ext;
        abytes_o = 2'd3;
      end
      ST_ERASE: begin
        code_o   = OPC_ERASE;
        addr_o   = row_ext;
        abytes_o = 2'd3;
      end
      ST_POLL: begin
        code_o   = OPC_GETF;
        addr_o   = ADDR_W'(STATUS_ADDR);
        abytes_o = 2'd1;
        len_o    = LEN_W'(1);
      end
      ST_CACHE: begin
        code_o   = fast_i ? OPC_CACHE_F : OPC_CACHE;
        addr_o   = col_ext;
        abytes_o = 2'd2;
        dummy_o  = fast_i ? 2'(FAST_DUMMY) : 2'd0;
        len_o    = LEN_W'(PAGE_BYTES);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nand_status_dec.sv
module nand_status_dec
  import nand_ctrl_pkg::*;
(
  input  kind_e       kind_i,
  input  logic [7:0]  status_i,
  output logic        busy_o,
  output logic [2:0]  result_o
);
  assign busy_o = status_i[0];

  always_comb begin
    result_o = RES_OK;
    unique case (kind_i)
      KIND_READ: begin
        unique case (status_i[5:4])
          2'b00:   result_o = RES_OK;
          2'b01:   result_o = RES_CORR;
          default: result_o = RES_UNCOR;  // 11 treated as uncorrectable
        endcase
      end
      KIND_PROG:  result_o = status_i[3] ? RES_FAIL : RES_OK;
      KIND_ERASE: result_o = status_i[2] ? RES_FAIL : RES_OK;
      default:    result_o = RES_OK;
    endcase
  end
endmodule

// File: rtl/nand_poll_cnt.sv
module nand_poll_cnt #(
  parameter int MAX_POLLS = 1024,
  parameter int CNT_W     = $clog2(MAX_POLLS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hit_i,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (hit_i) cnt_q <= cnt_q + 1'b1;
  end

  // current busy reply is the last one allowed
  assign last_o = (cnt_q == CNT_W'(MAX_POLLS - 1));
endmodule

// File: rtl/nand_page_ctrl.sv
module nand_page_ctrl
  import nand_ctrl_pkg::*;
#(
  parameter int ROW_W      = 24,
  parameter int COL_W      = 12,
  parameter int PAGE_BYTES = 2112,
  parameter int FAST_DUMMY = 1,
  parameter int MAX_POLLS  = 1024,
  parameter int LEN_W      = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_fast_i,
  input  logic              req_keep_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        result_o,
  output logic              op_valid_o,
  output logic [7:0]        op_code_o,
  output logic [23:0]       op_addr_o,
  output logic [1:0]        op_addr_bytes_o,
  output logic [1:0]        op_dummy_o,
  output logic [LEN_W-1:0]  op_len_o,
  output logic              op_write_o,
  input  logic              op_done_i,
  input  logic [7:0]        op_rdata_i
);
  step_e             step_q;
  kind_e             kind_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              fast_q, keep_q;
  logic              done_q;
  logic [2:0]        result_q, ecc_q;

  logic       accept, fire, poll_fire, st_busy, poll_last;
  logic [2:0] st_res;

  assign accept    = (step_q == ST_IDLE) && req_valid_i && (req_kind_i != 2'd3);
  assign fire      = (step_q != ST_IDLE) && op_done_i;
  assign poll_fire = fire && (step_q == ST_POLL);

  nand_op_fmt #(
    .ROW_W(ROW_W), .COL_W(COL_W), .PAGE_BYTES(PAGE_BYTES),
    .FAST_DUMMY(FAST_DUMMY), .LEN_W(LEN_W)
  ) u_fmt (
    .step_i   (step_q),
    .row_i    (row_q),
    .col_i    (col_q),
    .fast_i   (fast_q),
    .keep_i   (keep_q),
    .code_o   (op_code_o),
    .addr_o   (op_addr_o),
    .abytes_o (op_addr_bytes_o),
    .dummy_o  (op_dummy_o),
    .len_o    (op_len_o),
    .write_o  (op_write_o)
  );

  nand_status_dec u_dec (
    .kind_i   (kind_q),
    .status_i (op_rdata_i),
    .busy_o   (st_busy),
    .result_o (st_res)
  );

  nand_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .hit_i  (poll_fire && st_busy),
    .last_o (poll_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= ST_IDLE;
      kind_q   <= KIND_READ;
      row_q    <= '0;
      col_q    <= '0;
      fast_q   <= 1'b0;
      keep_q   <= 1'b0;
      done_q   <= 1'b0;
      result_q <= RES_OK;
      ecc_q    <= RES_OK;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        kind_q <= kind_e'(req_kind_i);
        row_q  <= req_row_i;
        col_q  <= req_col_i;
        fast_q <= req_fast_i;
        keep_q <= req_keep_i;
        step_q <= (req_kind_i == KIND_READ) ? ST_PGRD : ST_WREN;
      end else if (fire) begin
        unique case (step_q)
          ST_WREN:  step_q <= (kind_q == KIND_PROG) ? ST_LOAD : ST_ERASE;
          ST_LOAD:  step_q <= ST_EXEC;
          ST_EXEC,
          ST_PGRD,
          ST_ERASE: step_q <= ST_POLL;
          ST_POLL: begin
            if (st_busy) begin
              if (poll_last) begin
                step_q   <= ST_IDLE;
                done_q   <= 1'b1;
                result_q <= RES_TIMEOUT;
              end
            end else if (kind_q == KIND_READ) begin
              ecc_q  <= st_res;
              step_q <= ST_CACHE;
            end else begin
              step_q   <= ST_IDLE;
              done_q   <= 1'b1;
              result_q <= st_res;
            end
          end
          ST_CACHE: begin
            step_q   <= ST_IDLE;
            done_q   <= 1'b1;
            result_q <= ecc_q;
          end
          default: step_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o     = (step_q != ST_IDLE);
  assign op_valid_o = (step_q != ST_IDLE);
  assign done_o     = done_q;
  assign result_o   = result_q;
endmodule

// File: rtl/nand_page_ctrl_chk.sv
module nand_page_ctrl_chk #(
  parameter int LEN_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_o,
  input logic [2:0]       result_o,
  input logic             op_valid_o,
  input logic [7:0]       op_code_o,
  input logic [23:0]      op_addr_o,
  input logic [1:0]       op_addr_bytes_o,
  input logic [LEN_W-1:0] op_len_o,
  input logic             op_write_o,
  input logic             op_done_i
);
  // R12
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && !op_done_i |=> op_valid_o && $stable(op_code_o) && $stable(op_addr_o));

  // R4
  poll_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && op_code_o == 8'h0F |->
      op_addr_o == 24'hC0 && op_addr_bytes_o == 2'd1 && op_len_o == LEN_W'(1) && !op_write_o);

  // R2
  rd_then_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && op_done_i && op_code_o == 8'h13 |=> op_valid_o && op_code_o == 8'h0F);

  // R5
  wren_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && op_done_i && op_code_o == 8'h06 |=>
      op_valid_o && (op_code_o == 8'h02 || op_code_o == 8'h84 || op_code_o == 8'hD8));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !op_valid_o && result_o <= 3'd4);
endmodule

bind nand_page_ctrl nand_page_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .done_o          (done_o),
  .result_o        (result_o),
  .op_valid_o      (op_valid_o),
  .op_code_o       (op_code_o),
  .op_addr_o       (op_addr_o),
  .op_addr_bytes_o (op_addr_bytes_o),
  .op_len_o        (op_len_o),
  .op_write_o      (op_write_o),
  .op_done_i       (op_done_i)
);

// File: tb/sim_nand_page_ctrl.sv
module sim_nand_page_ctrl;
  localparam int ROW_W      = 24;
  localparam int COL_W      = 12;
  localparam int PAGE_BYTES = 64;
  localparam int FAST_DUMMY = 1;
  localparam int MAX_POLLS  = 4;
  localparam int LEN_W      = $clog2(PAGE_BYTES + 1);

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0;
  logic [1:0]       req_kind_i = '0;
  logic [ROW_W-1:0] req_row_i = '0;
  logic [COL_W-1:0] req_col_i = '0;
  logic             req_fast_i = 1'b0;
  logic             req_keep_i = 1'b0;
  logic             busy_o, done_o, op_valid_o, op_write_o;
  logic [2:0]       result_o;
  logic [7:0]       op_code_o;
  logic [23:0]      op_addr_o;
  logic [1:0]       op_addr_bytes_o, op_dummy_o;
  logic [LEN_W-1:0] op_len_o;
  logic             op_done_i = 1'b0;
  logic [7:0]       op_rdata_i = '0;

  always #10 clk = ~clk;

  nand_page_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .PAGE_BYTES(PAGE_BYTES),
    .FAST_DUMMY(FAST_DUMMY), .MAX_POLLS(MAX_POLLS)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_kind_i(req_kind_i), .req_row_i(req_row_i),
    .req_col_i(req_col_i), .req_fast_i(req_fast_i), .req_keep_i(req_keep_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .op_valid_o(op_valid_o), .op_code_o(op_code_o), .op_addr_o(op_addr_o),
    .op_addr_bytes_o(op_addr_bytes_o), .op_dummy_o(op_dummy_o), .op_len_o(op_len_o),
    .op_write_o(op_write_o), .op_done_i(op_done_i), .op_rdata_i(op_rdata_i)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  int    exp_code_q[$];
  int    exp_addr_q[$];
  string exp_tag_q[$];
  bit    exp_fast_q[$];
  int    stat_q[$];
  int    exp_res_q[$];
  string res_tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic exp_op(input int code, input int addr, input string tag, input bit fast = 0);
    exp_code_q.push_back(code);
    exp_addr_q.push_back(addr);
    exp_tag_q.push_back(tag);
    exp_fast_q.push_back(fast);
  endtask

  task automatic exp_res(input int r, input string tag);
    exp_res_q.push_back(r);
    res_tag_q.push_back(tag);
  endtask

  // sequencer model: each command completes two cycles after it appears
  int wcnt = 0;
  always @(negedge clk) begin
    if (op_done_i) begin
      op_done_i = 1'b0;
      wcnt = 0;
    end else if (op_valid_o) begin
      if (wcnt < 1) wcnt++;
      else begin
        if (exp_code_q.size() == 0) begin
          chk(0, "R10 unexpected command", op_code_o, 0);
        end else begin
          int c, a, ab, ln, dm;
          bit wr, f;
          string t;
          c = exp_code_q.pop_front();
          a = exp_addr_q.pop_front();
          t = exp_tag_q.pop_front();
          f = exp_fast_q.pop_front();
          ab = 0; ln = 0; wr = 0; dm = 0;
          case (c)
            8'h13, 8'h10, 8'hD8: ab = 3;
            8'h0F: begin ab = 1; ln = 1; end
            8'h03, 8'h0B: begin ab = 2; ln = PAGE_BYTES; dm = f ? FAST_DUMMY : 0; end
            8'h02, 8'h84: begin ab = 2; ln = PAGE_BYTES; wr = 1; end
            default: ;
          endcase
          chk(op_code_o == c, {t, " opcode"}, op_code_o, c);
          chk(int'(op_addr_o) == a, {t, " address"}, op_addr_o, a);
          chk(int'(op_addr_bytes_o) == ab && int'(op_len_o) == ln &&
              op_write_o == wr && int'(op_dummy_o) == dm, {t, " format"},
              {op_addr_bytes_o, op_dummy_o, op_write_o}, {ab[1:0], dm[1:0], wr});
        end
        op_rdata_i = (op_code_o == 8'h0F && stat_q.size() > 0) ? 8'(stat_q.pop_front()) : 8'h00;
        op_done_i = 1'b1;
      end
    end
  end

  // result monitor
  always @(negedge clk) begin
    if (done_o) begin
      if (exp_res_q.size() == 0) chk(0, "R10 unexpected done", result_o, 0);
      else chk(int'(result_o) == exp_res_q[0], res_tag_q[0], result_o, exp_res_q[0]);
      if (exp_res_q.size() > 0) begin
        void'(exp_res_q.pop_front());
        void'(res_tag_q.pop_front());
      end
    end
  end

  task automatic issue(input int kind, input int row, input int col,
                       input bit fast = 0, input bit keep = 0);
    req_kind_i  = 2'(kind);
    req_row_i   = ROW_W'(row);
    req_col_i   = COL_W'(col);
    req_fast_i  = fast;
    req_keep_i  = keep;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_seq(input int row, input int col, input int st, input int res,
                          input string tag, input bit fast = 0);
    exp_op(8'h13, row, "R2");
    exp_op(8'h0F, 8'hC0, "R4"); stat_q.push_back(8'h01);
    exp_op(8'h0F, 8'hC0, "R4"); stat_q.push_back(st);
    exp_op(fast ? 8'h0B : 8'h03, col, fast ? "R3" : "R2", fast);
    exp_res(res, tag);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      chk(0, "watchdog", cycles, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !op_valid_o && !done_o && result_o == 0, "R1 reset", {busy_o, op_valid_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 R7 plain read, ecc clean
    read_seq(24'h012345, 12'h010, 8'h00, 0, "R7 clean");
    issue(0, 24'h012345, 12'h010);
    wait_done();
    // R3 fast read, corrected
    read_seq(24'h000777, 12'h7FF, 8'h10, 1, "R7 corrected", 1);
    issue(0, 24'h000777, 12'h7FF, 1);
    wait_done();
    // R7 uncorrectable 10 and 11
    read_seq(24'h00ABCD, 12'h004, 8'h20, 2, "R7 uncorrectable");
    issue(0, 24'h00ABCD, 12'h004);
    wait_done();
    read_seq(24'h00ABCE, 12'h005, 8'h30, 2, "R7 code 11");
    issue(0, 24'h00ABCE, 12'h005);
    wait_done();

    // R5 program, clean
    exp_op(8'h06, 0, "R5"); exp_op(8'h02, 12'h123, "R5"); exp_op(8'h10, 24'h040506, "R5");
    exp_op(8'h0F, 8'hC0, "R4"); stat_q.push_back(8'h01);
    exp_op(8'h0F, 8'hC0, "R4"); stat_q.push_back(8'h00);
    exp_res(0, "R5 program ok");
    issue(1, 24'h040506, 12'h123);
    // R10 request while busy ignored (erase kind, would add 0xD8)
    repeat (2) @(negedge clk);
    issue(2, 24'h0000FF, 0);
    wait_done();

    // R8 keep-load program failing
    exp_op(8'h06, 0, "R5"); exp_op(8'h84, 12'h020, "R5 keep"); exp_op(8'h10, 24'h000100, "R5");
    exp_op(8'h0F, 8'hC0, "R4"); stat_q.push_back(8'h08);
    exp_res(3, "R8 program fail");
    issue(1, 24'h000100, 12'h020, 0, 1);
    wait_done();
    // R8 program ignores erase-fail bit
    exp_op(8'h06, 0, "R5"); exp_op(8'h02, 0, "R5"); exp_op(8'h10, 24'h000101, "R5");
    exp_op(8'h0F, 8'hC0, "R4"); stat_q.push_back(8'h04);
    exp_res(0, "R8 program ignores bit2");
    issue(1, 24'h000101, 0);
    wait_done();

    // R6 erase fail, erase ignoring program-fail bit
    exp_op(8'h06, 0, "R6"); exp_op(8'hD8, 24'h000200, "R6");
    exp_op(8'h0F, 8'hC0, "R4"); stat_q.push_back(8'h04);
    exp_res(3, "R8 erase fail");
    issue(2, 24'h000200, 0);
    wait_done();
    exp_op(8'h06, 0, "R6"); exp_op(8'hD8, 24'h000240, "R6");
    exp_op(8'h0F, 8'hC0, "R4"); stat_q.push_back(8'h09);
    exp_op(8'h0F, 8'hC0, "R4"); stat_q.push_back(8'h08);
    exp_res(0, "R8 erase ignores bit3");
    issue(2, 24'h000240, 0);
    wait_done();

    // R9 timeout: no cache read after MAX_POLLS busy replies
    exp_op(8'h13, 24'h000300, "R9");
    for (int i = 0; i < MAX_POLLS; i++) begin
      exp_op(8'h0F, 8'hC0, "R9"); stat_q.push_back(8'h01);
    end
    exp_res(4, "R9 timeout");
    issue(0, 24'h000300, 0);
    wait_done();
    repeat (4) @(negedge clk);
    chk(!op_valid_o && exp_code_q.size() == 0, "R9 no command after timeout", op_valid_o, 0);

    // R9 busy clears on the last allowed poll
    exp_op(8'h13, 24'h000301, "R9");
    for (int i = 0; i < MAX_POLLS - 1; i++) begin
      exp_op(8'h0F, 8'hC0, "R9"); stat_q.push_back(8'h01);
    end
    exp_op(8'h0F, 8'hC0, "R9"); stat_q.push_back(8'h10);
    exp_op(8'h03, 12'h008, "R9 continues");
    exp_res(1, "R9 last poll clears");
    issue(0, 24'h000301, 12'h008);
    wait_done();

    // R10 kind 3 ignored
    issue(3, 24'h000400, 0);
    chk(!busy_o, "R10 kind 3 ignored", busy_o, 0);
    repeat (3) @(negedge clk);
    chk(!op_valid_o, "R10 kind 3 no command", op_valid_o, 0);

    // R11 request in the done cycle
    exp_op(8'h06, 0, "R6"); exp_op(8'hD8, 24'h000500, "R6");
    exp_op(8'h0F, 8'hC0, "R4"); stat_q.push_back(8'h00);
    exp_res(0, "R11 first");
    exp_op(8'h06, 0, "R11"); exp_op(8'hD8, 24'h000540, "R11");
    exp_op(8'h0F, 8'hC0, "R11"); stat_q.push_back(8'h04);
    exp_res(3, "R11 back-to-back");
    issue(2, 24'h000500, 0);
    while (!done_o) @(negedge clk);
    chk(!busy_o, "R11 idle in done cycle", busy_o, 0);
    issue(2, 24'h000540, 0);
    chk(busy_o, "R11 accepted in done cycle", busy_o, 1);
    wait_done();

    repeat (4) @(negedge clk);
    chk(exp_code_q.size() == 0 && exp_res_q.size() == 0, "R10 all items consumed",
        exp_code_q.size(), 0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule